// File: doc/BRIEF.md
# Framed Word Transmitter With XOR Checksum

This block assembles a fixed-length frame of 16-bit words and hands it, one word at a time, to a serial port transmit register through a valid/ready word interface. A single start pulse carries the frame's type code, a single/multi-frame flag, a sample count and a byte-swap select. The block then reads payload samples from a small external buffer through a read port whose data is valid in the same cycle as the address.

The frame always has the same length. It opens with four header words: the frame length, the type code, the mode flag and the effective sample count. The payload samples come next, optionally with their bytes exchanged. Zero words pad the frame to its fixed length. The last word is the XOR of every word sent before it. Each word leaves as a 32-bit write with its upper half cleared. The block holds a word for as long as the transmitter is not ready.

Top module: `fwtx_framer`

## Requirements
- R1: Every frame consists of exactly FRAME_LEN handshaken words, whatever sample count is requested.
- R2: Word positions 0 to 3 carry, in this order: FRAME_LEN; the type code; the mode flag in bit 0 (1 = multi-frame, 0 = single frame) with all other bits zero; the effective sample count.
- R3: For payload index i (word position 4+i), the word is taken from buffer address i when i is below the effective count. Positions from 4+count up to FRAME_LEN-2 are sent as zero.
- R4: With the swap select at 1, each payload word is sent with bits [15:8] and [7:0] exchanged. With it at 0, the word is sent unchanged. Header, padding and checksum words are never swapped.
- R5: Word position FRAME_LEN-1 is the bitwise XOR of the FRAME_LEN-1 words sent before it in the same frame.
- R6: While tx_valid is high and tx_ready is low, the word and tx_valid are held. The frame advances only on a cycle where both are high.
- R7: Bits [31:16] of every transmit write are zero.
- R8: A requested count above FRAME_LEN-5 is clamped to FRAME_LEN-5. That clamped value is used both in the count word and in the payload.
- R9: busy rises in the cycle after a start is accepted while idle. It falls in the cycle after the checksum handshake. A start seen while busy is high is ignored and changes nothing in the frame in flight.
- R10: done is high for exactly one cycle, in the cycle after the checksum handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, taken when idle |
| start_type | input | 16 | Type code for the header |
| start_multi | input | 1 | Mode flag: 1 multi-frame, 0 single |
| start_count | input | 16 | Requested number of payload samples |
| start_swap | input | 1 | 1 exchanges payload bytes |
| buf_addr | output | 4 | Payload buffer read address |
| buf_data | input | 16 | Payload buffer read data, same cycle |
| tx_data | output | 32 | Transmit write word |
| tx_valid | output | 1 | Transmit write request |
| tx_ready | input | 1 | Transmitter can take the word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
The bench builds the block with FRAME_LEN set to 10. This leaves five payload slots, so a short frame reaches every region of the layout: header, used payload, zero padding and checksum. It also makes a requested count of 9 exceed the maximum, which drives the clamp. The frames run with the transmitter always ready and with a pseudo-random ready pattern, so stalls fall on header, payload and checksum words alike. A start pulse is injected mid-frame to show that it is dropped.

// File: rtl/fwtx_pkg.sv
package fwtx_pkg;
   // Fixed header layout: word positions are part of the frame format
   localparam int HDR_WORDS = 4;
   localparam int POS_LEN   = 0;
   localparam int POS_TYPE  = 1;
   localparam int POS_MODE  = 2;
   localparam int POS_COUNT = 3;
   // Words outside the payload region: header plus checksum
   localparam int FIXED_WORDS = HDR_WORDS + 1;
endpackage

// File: rtl/fwtx_seq.sv
module fwtx_seq #(
   parameter int FRAME_LEN = 16,
   localparam int PW = $clog2(FRAME_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          xfer,
   output logic          accept,
   output logic          busy,
   output logic          last,
   output logic          done,
   output logic [PW-1:0] pos
);
   localparam logic [PW-1:0] LAST_POS = PW'(FRAME_LEN - 1);

   assign accept = start && !busy;
   assign last   = (pos == LAST_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         pos  <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy <= 1'b1;
            pos  <= '0;
         end else if (busy && xfer) begin
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
               pos  <= '0;
            end else begin
               pos <= pos + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fwtx_xor_acc.sv
module fwtx_xor_acc #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              en,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] acc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc <= '0;
      else if (clear) acc <= '0;
      else if (en)    acc <= acc ^ din;
   end
endmodule

// File: rtl/fwtx_word_sel.sv
module fwtx_word_sel
   import fwtx_pkg::*;
#(
   parameter int FRAME_LEN = 16,
   parameter int WORD_W    = 16,
   localparam int PW = $clog2(FRAME_LEN)
) (
   input  logic [PW-1:0]     pos,
   input  logic [WORD_W-1:0] hdr_type,
   input  logic              hdr_multi,
   input  logic [WORD_W-1:0] hdr_count,
   input  logic              swap,
   input  logic [WORD_W-1:0] buf_data,
   input  logic [WORD_W-1:0] acc,
   output logic [PW-1:0]     buf_addr,
   output logic [WORD_W-1:0] word
);
   localparam int HALF = WORD_W / 2;
   localparam logic [PW-1:0] LAST_POS = PW'(FRAME_LEN - 1);

   logic [PW-1:0]     idx;
   logic [WORD_W-1:0] swapped, payload;
   logic              used;

   assign idx      = pos - PW'(HDR_WORDS);
   assign buf_addr = idx;
   assign used     = (WORD_W'(idx) < hdr_count);

   // Byte exchange: upper and lower halves of the word trade places
   genvar b;
   generate
      for (b = 0; b < HALF; b++) begin : g_swap
         assign swapped[b]        = buf_data[b + HALF];
         assign swapped[b + HALF] = buf_data[b];
      end
   endgenerate

   assign payload = !used ? '0 : (swap ? swapped : buf_data);

   always_comb begin
      if (pos == PW'(POS_LEN))        word = WORD_W'(FRAME_LEN);
      else if (pos == PW'(POS_TYPE))  word = hdr_type;
      else if (pos == PW'(POS_MODE))  word = WORD_W'(hdr_multi);
      else if (pos == PW'(POS_COUNT)) word = hdr_count;
      else if (pos == LAST_POS)       word = acc;
      else                            word = payload;
   end
endmodule

// File: rtl/fwtx_framer.sv
module fwtx_framer
   import fwtx_pkg::*;
#(
   parameter int FRAME_LEN = 16,
   parameter int WORD_W    = 16,
   parameter int OUT_W     = 32,
   localparam int PW = $clog2(FRAME_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] start_type,
   input  logic              start_multi,
   input  logic [WORD_W-1:0] start_count,
   input  logic              start_swap,
   output logic [PW-1:0]     buf_addr,
   input  logic [WORD_W-1:0] buf_data,
   output logic [OUT_W-1:0]  tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              busy,
   output logic              done
);
   localparam int MAX_SAMP = FRAME_LEN - FIXED_WORDS;
   localparam logic [WORD_W-1:0] MAX_CNT = WORD_W'(MAX_SAMP);

   initial begin
      if (FRAME_LEN < FIXED_WORDS + 1)
         $error("FRAME_LEN must leave room for at least one payload word");
      if (FRAME_LEN >= (1 << WORD_W))
         $error("FRAME_LEN must fit in one word");
      if (WORD_W % 2 != 0)
         $error("WORD_W must be even for the byte exchange");
      if (OUT_W < WORD_W)
         $error("OUT_W must be at least WORD_W");
   end

   logic              accept, last, xfer;
   logic [PW-1:0]     pos;
   logic [WORD_W-1:0] word, acc;
   logic [WORD_W-1:0] r_type, r_count;
   logic              r_multi, r_swap;

   assign tx_valid = busy;
   assign xfer     = tx_valid && tx_ready;

   // Command fields are captured once per frame; later starts are dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_type  <= '0;
         r_count <= '0;
         r_multi <= 1'b0;
         r_swap  <= 1'b0;
      end else if (accept) begin
         r_type  <= start_type;
         r_count <= (start_count > MAX_CNT) ? MAX_CNT : start_count;
         r_multi <= start_multi;
         r_swap  <= start_swap;
      end
   end

   fwtx_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .xfer(xfer),
      .accept(accept), .busy(busy), .last(last), .done(done), .pos(pos)
   );

   fwtx_xor_acc #(.WORD_W(WORD_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clear(accept),
      .en(xfer && !last), .din(word), .acc(acc)
   );

   fwtx_word_sel #(.FRAME_LEN(FRAME_LEN), .WORD_W(WORD_W)) u_sel (
      .pos(pos), .hdr_type(r_type), .hdr_multi(r_multi),
      .hdr_count(r_count), .swap(r_swap), .buf_data(buf_data),
      .acc(acc), .buf_addr(buf_addr), .word(word)
   );

   generate
      if (OUT_W > WORD_W) begin : g_pad
         assign tx_data = {{(OUT_W - WORD_W){1'b0}}, word};
      end else begin : g_direct
         assign tx_data = word;
      end
   endgenerate
endmodule

// File: rtl/fwtx_framer_chk.sv
module fwtx_framer_chk #(
   parameter int FRAME_LEN = 16,
   parameter int WORD_W    = 16,
   parameter int OUT_W     = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [OUT_W-1:0] tx_data,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic             busy,
   input logic             done
);
   localparam int CW = $clog2(FRAME_LEN + 1) + 1;
   logic [CW-1:0] hs_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hs_cnt <= '0;
      else if (done) hs_cnt <= CW'(tx_valid && tx_ready);
      else           hs_cnt <= hs_cnt + CW'(tx_valid && tx_ready);
   end

   AST_FRAME_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> hs_cnt == CW'(FRAME_LEN)); // R1
   AST_FIRST_WORD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> tx_data[WORD_W-1:0] == WORD_W'(FRAME_LEN)); // R2
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data)); // R6
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> tx_data[OUT_W-1:WORD_W] == '0); // R7
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !(tx_valid && tx_ready)) |=> busy); // R9
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy)); // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
endmodule

bind fwtx_framer fwtx_framer_chk #(
   .FRAME_LEN(FRAME_LEN), .WORD_W(WORD_W), .OUT_W(OUT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data),
   .tx_valid(tx_valid), .tx_ready(tx_ready), .busy(busy), .done(done)
);

// File: tb/fwtx_framer_test.sv
module fwtx_framer_test;
   localparam int CLK_P  = 10;
   localparam int FL     = 10;
   localparam int MAXS   = FL - 5;
   localparam int PW     = $clog2(FL);

   logic clk = 0, rst_n = 0;
   logic start = 0, start_multi = 0, start_swap = 0;
   logic [15:0] start_type = 0, start_count = 0;
   logic [PW-1:0] buf_addr;
   logic [15:0] buf_data;
   logic [31:0] tx_data;
   logic tx_valid, tx_ready = 1, busy, done;

   logic [15:0] mem [0:(1<<PW)-1];
   assign buf_data = mem[buf_addr];

   int tests = 0, fails = 0, frames = 0, words_in = 0;
   int rdy_mode = 0;
   logic [7:0] lfsr = 8'h5A;
   logic [31:0] expq [$];
   string tagq [$];

   fwtx_framer #(.FRAME_LEN(FL)) uut (.*);

   always #(CLK_P/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Ready pattern changes just after each rising edge
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0];
   end

   // Monitor: compare each word taken at the coming edge with the scoreboard
   always @(negedge clk) begin
      if (rst_n && tx_valid && tx_ready) begin
         if (expq.size() == 0) begin
            check(0, "R1 extra word", tx_data, 32'h0);
         end else begin
            logic [31:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(tx_data == e, t, tx_data, e);
         end
         words_in++;
      end
      if (rst_n && done) begin
         check(words_in == FL, "R1 words per frame", words_in, FL);
         check(!busy, "R10 busy low at done", busy, 0);
         words_in = 0;
         frames++;
      end
   end

   function automatic logic [15:0] bswap(input logic [15:0] w);
      return {w[7:0], w[15:8]};
   endfunction

   task automatic send(input logic [15:0] typ, input bit multi,
                       input logic [15:0] cnt, input bit swp, input bit poke);
      int eff;
      logic [15:0] w, chk;
      int target;
      eff = (cnt > MAXS) ? MAXS : int'(cnt);
      chk = 0;
      for (int p = 0; p < FL - 1; p++) begin
         if (p == 0) w = 16'(FL);
         else if (p == 1) w = typ;
         else if (p == 2) w = {15'h0, multi};
         else if (p == 3) w = 16'(eff);
         else if (p - 4 < eff) w = swp ? bswap(mem[p-4]) : mem[p-4];
         else w = 0;
         chk ^= w;
         expq.push_back({16'h0, w});
         if (p < 3) tagq.push_back("R2 header");
         else if (p == 3) tagq.push_back("R8 count word");
         else if (swp) tagq.push_back("R4 swapped payload");
         else tagq.push_back("R3 payload");
      end
      expq.push_back({16'h0, chk});
      tagq.push_back("R5 checksum");
      target = frames + 1;
      @(negedge clk);
      start = 1; start_type = typ; start_multi = multi;
      start_count = cnt; start_swap = swp;
      @(negedge clk);
      start = 0; start_type = 16'hDEAD; start_count = 1; start_swap = ~swp;
      check(busy == 1, "R9 busy after start", busy, 1);
      if (poke) begin
         repeat (2) @(negedge clk);
         start = 1; start_multi = ~multi;
         @(negedge clk);
         start = 0;
      end
      wait (frames == target);
      repeat (3) @(negedge clk);
      check(busy == 0 && expq.size() == 0, "R9 no extra frame", busy, 0);
   endtask

   initial begin
      for (int i = 0; i < (1<<PW); i++) mem[i] = 16'h1100 * 16'(i + 1) + 16'h0F * 16'(i);
      repeat (3) @(negedge clk);
      check(busy == 0 && tx_valid == 0 && done == 0, "R9 reset state", {busy, tx_valid, done}, 0);
      rst_n = 1;
      @(negedge clk);
      send(16'h0031, 0, 3, 0, 0);           // R3 partial payload, plain
      send(16'h0A52, 1, 5, 1, 0);           // R4 full payload swapped
      rdy_mode = 1;                          // R6 stalls
      send(16'h7777, 0, 9, 0, 0);           // R8 clamp
      send(16'h00C3, 1, 0, 1, 1);           // R3 zero samples, R9 ignored start
      send(16'hFFFF, 0, 2, 1, 0);           // R7 R5 with stalls
      rdy_mode = 0;
      send(16'h1234, 1, 16'hFFFF, 1, 1);    // R8 extreme clamp, R9
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule